// File: doc/BRIEF.md
# Sleep Mode and Clock Gating Controller

This block decides when a processor core may go to sleep, which clock domains stay alive while it sleeps, and how it comes back. A sleep-instruction strobe puts the block to sleep only when the sleep-enable input is high and the two-bit mode field holds a legal code. Three depths are offered: idle, ADC noise reduction and power-down. Each depth drives its own pattern of gate enables for the CPU, flash, I/O, ADC and main-oscillator domains. Each depth also accepts its own subset of the six wake-request inputs.

An accepted wake-up turns every clock domain back on. The CPU is then held for a programmable start-up count plus four further cycles, after which a single-cycle pulse says that the pending interrupt may be serviced. A reset request that arrives while the block is asleep or waking ends the sleep at once and raises a restart-from-reset-vector pulse instead. In power-down, a brown-out-sleep input can switch the brown-out detector enable off for the length of the sleep. When it does, the wake path uses the longer reset-length count in place of the start-up count. Entering idle or ADC noise reduction with the ADC switched on produces one conversion-start pulse.

The state machine has five states. ST_RUN is normal operation. ST_SLEEP is asleep with the mode's clock mask applied. ST_STARTUP waits out the start-up count. ST_HALT holds the CPU for four cycles. ST_RESUME is a one-cycle interrupt hand-off.

The transitions are as follows. Enter: ST_RUN to ST_SLEEP when the strobe, the sleep-enable and a legal mode are all present. Wake: ST_SLEEP to ST_STARTUP on an accepted wake request. Settle: ST_STARTUP to ST_HALT when the count runs out. Release: ST_HALT to ST_RESUME after four cycles. Return: ST_RESUME to ST_RUN. Abort: ST_SLEEP, ST_STARTUP or ST_HALT to ST_RUN on a reset request.

Top module: `sleep_ctrl`

## Requirements
- R1: The strobe starts a sleep only when sleep_en is 1 and mode is not 2'b11. Otherwise the strobe is ignored: sleeping stays 0 and all five clock enables stay 1.
- R2: Mode 2'b00 (idle) drives clk_cpu_en=0 and clk_flash_en=0 while asleep. In the same state clk_io_en, clk_adc_en and osc_en stay 1.
- R3: Mode 2'b01 (ADC noise reduction) drives clk_cpu_en, clk_flash_en and clk_io_en to 0 while asleep. clk_adc_en and osc_en stay 1.
- R4: Mode 2'b10 (power-down) drives all five clock enables to 0 while asleep.
- R5: The wake inputs are wake_req[0] external interrupt/pin change, [1] EEPROM ready, [2] serial start condition, [3] ADC complete, [4] watchdog and [5] other I/O. Idle accepts all six. ADC noise reduction accepts bits 0 to 4. Power-down accepts bits 0, 2 and 4. A request that is not accepted leaves the block asleep.
- R6: Suppose an accepted wake request is sampled on clock edge E. From E on, all clock enables are 1 and cpu_halt stays 1 for max(N,1)+4 cycles, where N is startup_cycles. irq_resume is then 1 for exactly one cycle, the one that begins at edge E+max(N,1)+4, and cpu_halt is 0 in that cycle.
- R7: ext_rst sampled in the sleeping, start-up or halt phase returns the block to run at the next edge. reset_restart is then 1 for one cycle and irq_resume does not pulse.
- R8: bod_en is 1 except while asleep in power-down that was entered with bod_sleep=1. bod_en returns to 1 at the wake edge.
- R9: When the brown-out detector was off during the sleep, the start-up count N in R6 is taken from reset_cycles instead of startup_cycles.
- R10: adc_start is a one-cycle pulse in the first sleeping cycle. It is issued when idle or ADC noise reduction is entered with adc_on=1, and never on entry to power-down.
- R11: After reset, all clock enables are 1, bod_en is 1, and sleeping, cpu_halt, irq_resume, reset_restart and adc_start are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Active-low asynchronous reset of the controller |
| sleep_en | input | 1 | Sleep permission bit |
| sleep_strobe | input | 1 | One-cycle sleep instruction strobe |
| mode | input | 2 | Sleep depth: 00 idle, 01 ADC noise reduction, 10 power-down, 11 reserved |
| bod_sleep | input | 1 | Request to switch off the brown-out detector in power-down |
| adc_on | input | 1 | ADC is enabled |
| startup_cycles | input | CNT_W | Start-up count after wake |
| reset_cycles | input | CNT_W | Start-up count used when the brown-out detector was off |
| wake_req | input | 6 | Wake-request sources (bit map in R5) |
| ext_rst | input | 1 | Reset request arriving during sleep |
| clk_cpu_en | output | 1 | CPU clock gate enable |
| clk_flash_en | output | 1 | Flash clock gate enable |
| clk_io_en | output | 1 | I/O clock gate enable |
| clk_adc_en | output | 1 | ADC clock gate enable |
| osc_en | output | 1 | Main oscillator enable |
| bod_en | output | 1 | Brown-out detector enable |
| adc_start | output | 1 | Conversion-start pulse |
| sleeping | output | 1 | Block is in the sleeping state |
| cpu_halt | output | 1 | CPU held (asleep, starting up or in the four-cycle halt) |
| irq_resume | output | 1 | One-cycle permission to take the wake interrupt |
| reset_restart | output | 1 | One-cycle restart-from-reset-vector indication |

## Verification
The hardest case to reach is a wake request that the current mode rejects. To see it, the block must be held in a particular depth while a source that only a shallower depth accepts is driven. The block must then be shown to stay asleep before an accepted source releases it. The vector table pairs each depth with both accepted and rejected sources and checks the clock mask and the sleeping output after each request. The brown-out path needs power-down entered with bod_sleep set and two different count inputs. The bench then tells the two counts apart by the measured delay to irq_resume.

// File: rtl/slp_pkg.sv
package slp_pkg;

    typedef enum logic [1:0] {
        MODE_IDLE = 2'b00,
        MODE_ANR  = 2'b01,
        MODE_PD   = 2'b10,
        MODE_RSVD = 2'b11
    } slp_mode_e;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_SLEEP,
        ST_STARTUP,
        ST_HALT,
        ST_RESUME
    } slp_state_e;

    localparam int NUM_WAKE  = 6;
    localparam int WK_EXT    = 0;
    localparam int WK_EEPROM = 1;
    localparam int WK_SERIAL = 2;
    localparam int WK_ADC    = 3;
    localparam int WK_WDT    = 4;
    localparam int WK_OTHER  = 5;

    localparam int NUM_DOM   = 5;
    localparam int DOM_CPU   = 0;
    localparam int DOM_FLASH = 1;
    localparam int DOM_IO    = 2;
    localparam int DOM_ADC   = 3;
    localparam int DOM_OSC   = 4;

    function automatic logic src_allowed(slp_mode_e m, int s);
        case (m)
            MODE_IDLE: return 1'b1;
            MODE_ANR:  return (s != WK_OTHER);
            MODE_PD:   return (s == WK_EXT) || (s == WK_SERIAL) || (s == WK_WDT);
            default:   return 1'b0;
        endcase
    endfunction

    function automatic logic dom_alive(slp_mode_e m, int d);
        case (m)
            MODE_IDLE: return (d != DOM_CPU) && (d != DOM_FLASH);
            MODE_ANR:  return (d == DOM_ADC) || (d == DOM_OSC);
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/slp_wake_qual.sv
module slp_wake_qual
    import slp_pkg::*;
(
    input  slp_mode_e               mode,
    input  logic [NUM_WAKE-1:0]     req,
    output logic                    hit
);
    logic [NUM_WAKE-1:0] acc;

    for (genvar i = 0; i < NUM_WAKE; i++) begin : g_src
        assign acc[i] = req[i] & src_allowed(mode, i);
    end

    assign hit = |acc;
endmodule

// File: rtl/slp_clk_gate.sv
module slp_clk_gate
    import slp_pkg::*;
(
    input  logic                in_sleep,
    input  slp_mode_e           mode,
    output logic [NUM_DOM-1:0]  dom_en
);
    for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
        assign dom_en[d] = !in_sleep || dom_alive(mode, d);
    end
endmodule

// File: rtl/slp_delay_cnt.sv
module slp_delay_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/sleep_ctrl.sv
module sleep_ctrl
    import slp_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int HALT_CYC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep_en,
    input  logic             sleep_strobe,
    input  logic [1:0]       mode,
    input  logic             bod_sleep,
    input  logic             adc_on,
    input  logic [CNT_W-1:0] startup_cycles,
    input  logic [CNT_W-1:0] reset_cycles,
    input  logic [5:0]       wake_req,
    input  logic             ext_rst,
    output logic             clk_cpu_en,
    output logic             clk_flash_en,
    output logic             clk_io_en,
    output logic             clk_adc_en,
    output logic             osc_en,
    output logic             bod_en,
    output logic             adc_start,
    output logic             sleeping,
    output logic             cpu_halt,
    output logic             irq_resume,
    output logic             reset_restart
);
    localparam logic [CNT_W-1:0] HALT_LOAD = CNT_W'(HALT_CYC - 1);

    slp_state_e          state, state_nxt;
    slp_mode_e           mode_in, mode_q;
    logic                bod_off_q;
    logic                wake_hit;
    logic                go_sleep;
    logic                abort;
    logic                cnt_load;
    logic [CNT_W-1:0]    cnt_val, cnt;
    logic [NUM_DOM-1:0]  dom_en;

    assign mode_in  = slp_mode_e'(mode);
    assign go_sleep = sleep_strobe && sleep_en && (mode_in != MODE_RSVD);
    assign abort    = ext_rst && (state inside {ST_SLEEP, ST_STARTUP, ST_HALT});

    slp_wake_qual u_wake (
        .mode (mode_q),
        .req  (wake_req),
        .hit  (wake_hit)
    );

    slp_clk_gate u_gate (
        .in_sleep (state == ST_SLEEP),
        .mode     (mode_q),
        .dom_en   (dom_en)
    );

    slp_delay_cnt #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .cnt      (cnt)
    );

    // next-state decision
    always_comb begin
        state_nxt = state;
        cnt_load  = 1'b0;
        cnt_val   = '0;
        unique case (state)
            ST_RUN: begin
                if (go_sleep) state_nxt = ST_SLEEP;
            end
            ST_SLEEP: begin
                if (ext_rst) begin
                    state_nxt = ST_RUN;
                end else if (wake_hit) begin
                    state_nxt = ST_STARTUP;
                    cnt_load  = 1'b1;
                    cnt_val   = bod_off_q ? reset_cycles : startup_cycles;
                end
            end
            ST_STARTUP: begin
                if (ext_rst) begin
                    state_nxt = ST_RUN;
                end else if (cnt <= CNT_W'(1)) begin
                    state_nxt = ST_HALT;
                    cnt_load  = 1'b1;
                    cnt_val   = HALT_LOAD;
                end
            end
            ST_HALT: begin
                if (ext_rst) begin
                    state_nxt = ST_RUN;
                end else if (cnt == '0) begin
                    state_nxt = ST_RESUME;
                end
            end
            ST_RESUME: state_nxt = ST_RUN;
            default:   state_nxt = ST_RUN;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_RUN;
        end else begin
            state <= state_nxt;
        end
    end

    // registered outputs and entry context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q        <= MODE_IDLE;
            bod_off_q     <= 1'b0;
            adc_start     <= 1'b0;
            reset_restart <= 1'b0;
        end else begin
            adc_start     <= 1'b0;
            reset_restart <= abort;
            if (state == ST_RUN && go_sleep) begin
                mode_q    <= mode_in;
                bod_off_q <= (mode_in == MODE_PD) && bod_sleep;
                adc_start <= adc_on && (mode_in != MODE_PD);
            end else if (state == ST_SLEEP && state_nxt != ST_SLEEP) begin
                bod_off_q <= 1'b0;
            end
        end
    end

    // state-decoded outputs
    always_comb begin
        clk_cpu_en   = dom_en[DOM_CPU];
        clk_flash_en = dom_en[DOM_FLASH];
        clk_io_en    = dom_en[DOM_IO];
        clk_adc_en   = dom_en[DOM_ADC];
        osc_en       = dom_en[DOM_OSC];
        bod_en       = !bod_off_q;
        sleeping     = (state == ST_SLEEP);
        cpu_halt     = (state == ST_SLEEP) || (state == ST_STARTUP) || (state == ST_HALT);
        irq_resume   = (state == ST_RESUME);
    end

    // R1
    r1_no_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && sleep_strobe && (!sleep_en || mode == 2'b11)) |=> !sleeping);

    // R2
    r2_idle_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sleeping && mode_q == MODE_IDLE) |-> (!clk_cpu_en && !clk_flash_en && clk_io_en && osc_en));

    // R4
    r4_pd_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sleeping && mode_q == MODE_PD) |-> (!osc_en && !clk_adc_en && !clk_io_en));

    // R6
    r6_resume_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_resume |=> !irq_resume);

    // R6
    r6_resume_after_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_resume) |-> $past(cpu_halt));

    // R7
    r7_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_halt && ext_rst) |=> (reset_restart && !cpu_halt && !irq_resume));

    // R8
    r8_bod_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bod_en |-> (sleeping && mode_q == MODE_PD));

    // R10
    r10_adc_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |-> (sleeping && mode_q != MODE_PD));
endmodule

// File: tb/test_sleep_ctrl.sv
module test_sleep_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sleep_en = 1'b0, sleep_strobe = 1'b0, bod_sleep = 1'b0, adc_on = 1'b0;
    logic [1:0] mode = 2'b00;
    logic [7:0] startup_cycles = 8'd2, reset_cycles = 8'd7;
    logic [5:0] wake_req = '0;
    logic       ext_rst = 1'b0;
    logic clk_cpu_en, clk_flash_en, clk_io_en, clk_adc_en, osc_en, bod_en;
    logic adc_start, sleeping, cpu_halt, irq_resume, reset_restart;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    sleep_ctrl i_sleep_ctrl (
        .clk(clk), .rst_n(rst_n), .sleep_en(sleep_en), .sleep_strobe(sleep_strobe),
        .mode(mode), .bod_sleep(bod_sleep), .adc_on(adc_on),
        .startup_cycles(startup_cycles), .reset_cycles(reset_cycles),
        .wake_req(wake_req), .ext_rst(ext_rst),
        .clk_cpu_en(clk_cpu_en), .clk_flash_en(clk_flash_en), .clk_io_en(clk_io_en),
        .clk_adc_en(clk_adc_en), .osc_en(osc_en), .bod_en(bod_en), .adc_start(adc_start),
        .sleeping(sleeping), .cpu_halt(cpu_halt), .irq_resume(irq_resume),
        .reset_restart(reset_restart)
    );

    // {mode[1:0], wake[5:0], mask{cpu,flash,io,adc,osc}[4:0], accepted}
    localparam int NV = 10;
    localparam logic [13:0] VEC [NV] = '{
        {2'b00, 6'b100000, 5'b00111, 1'b1},
        {2'b00, 6'b000010, 5'b00111, 1'b1},
        {2'b01, 6'b100000, 5'b00011, 1'b0},
        {2'b01, 6'b001000, 5'b00011, 1'b1},
        {2'b01, 6'b000010, 5'b00011, 1'b1},
        {2'b10, 6'b001000, 5'b00000, 1'b0},
        {2'b10, 6'b000010, 5'b00000, 1'b0},
        {2'b10, 6'b010000, 5'b00000, 1'b1},
        {2'b10, 6'b000100, 5'b00000, 1'b1},
        {2'b00, 6'b010000, 5'b00111, 1'b1}
    };

    function automatic logic [4:0] clkmask();
        return {clk_cpu_en, clk_flash_en, clk_io_en, clk_adc_en, osc_en};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic enter(input logic [1:0] m);
        @(negedge clk);
        mode = m; sleep_en = 1'b1; sleep_strobe = 1'b1;
        @(negedge clk);
        sleep_strobe = 1'b0;
    endtask

    // pulse a wake vector for one cycle; returns at the negedge after the sampling edge
    task automatic wake(input logic [5:0] w);
        wake_req = w;
        @(negedge clk);
        wake_req = '0;
    endtask

    // called right after wake(); k counts negedges, the first one being the one already passed
    task automatic wait_resume(output int k);
        k = 1;
        while (!irq_resume && k < 300) begin
            @(negedge clk);
            k++;
        end
    endtask

    initial begin
        int k;
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11 clocks", 32'(clkmask()), 32'h1f);
        check("R11 flags", {27'd0, bod_en, sleeping, cpu_halt, irq_resume, reset_restart}, 32'h10);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 adc_start", 32'(adc_start), 32'h0);

        // R1: strobe without enable, and reserved mode
        mode = 2'b00; sleep_en = 1'b0; sleep_strobe = 1'b1;
        @(negedge clk); sleep_strobe = 1'b0;
        check("R1 no enable", {27'd0, sleeping, clkmask()}, 32'h1f);
        enter(2'b11);
        check("R1 reserved mode", {27'd0, sleeping, clkmask()}, 32'h1f);

        // table walk: R2 R3 R4 R5 R6 R10
        adc_on = 1'b1;
        for (int i = 0; i < NV; i++) begin
            logic [1:0] m;
            logic [5:0] w;
            logic [4:0] msk;
            logic       acc;
            {m, w, msk, acc} = VEC[i];
            enter(m);
            check("R2/R3/R4 mask", 32'(clkmask()), 32'(msk));
            check("R10 adc_start on entry", 32'(adc_start), 32'(m != 2'b10));
            wake(w);
            check("R5 wake qualify", 32'(sleeping), 32'(!acc));
            if (!acc) wake(6'b000001);
            check("R6 clocks back", 32'(clkmask()), 32'h1f);
            wait_resume(k);
            check("R6 resume delay", 32'(k), 32'd7);
            check("R6 halt released", 32'(cpu_halt), 32'd0);
            @(negedge clk);
            check("R6 single pulse", 32'(irq_resume), 32'd0);
        end

        // R10: no pulse when the ADC is off
        adc_on = 1'b0;
        enter(2'b00);
        check("R10 adc off", 32'(adc_start), 32'd0);
        wake(6'b000001);
        wait_resume(k);

        // R6 boundary: zero start-up count behaves as one
        startup_cycles = 8'd0;
        enter(2'b01);
        wake(6'b010000);
        wait_resume(k);
        check("R6 zero count", 32'(k), 32'd6);
        startup_cycles = 8'd3;

        // R8/R9: brown-out off in power-down, long count
        bod_sleep = 1'b1;
        enter(2'b10);
        check("R8 bod off in pd", 32'(bod_en), 32'd0);
        wake(6'b000001);
        check("R8 bod restored", 32'(bod_en), 32'd1);
        wait_resume(k);
        check("R9 reset count used", 32'(k), 32'd12);

        // R8: idle with bod_sleep set leaves bod on, normal count
        enter(2'b00);
        check("R8 bod on in idle", 32'(bod_en), 32'd1);
        wake(6'b000001);
        wait_resume(k);
        check("R9 startup count used", 32'(k), 32'd8);
        bod_sleep = 1'b0;

        // R7: reset during sleep
        enter(2'b10);
        ext_rst = 1'b1;
        @(negedge clk); ext_rst = 1'b0;
        check("R7 restart", {28'd0, reset_restart, sleeping, cpu_halt, irq_resume}, 32'h8);
        @(negedge clk);
        check("R7 one pulse", {30'd0, reset_restart, irq_resume}, 32'h0);

        // R7: reset during start-up phase
        startup_cycles = 8'd10;
        enter(2'b00);
        wake(6'b000001);
        @(negedge clk);
        ext_rst = 1'b1;
        @(negedge clk); ext_rst = 1'b0;
        check("R7 restart in startup", {29'd0, reset_restart, cpu_halt, irq_resume}, 32'h4);
        repeat (15) begin
            @(negedge clk);
            if (irq_resume) check("R7 no resume", 32'd1, 32'd0);
        end
        check("R7 run clocks", 32'(clkmask()), 32'h1f);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule